// File: doc/BRIEF.md
# Local Bus Data-Drive Timer

This block sits on the bridge side of an 8/32-bit local bus and decides, cycle by cycle, when the bridge drives the shared data pins and when it leaves them at high impedance. Each access begins with a one-cycle reference pulse and a direction flag. Four 4-bit offsets in a 32-bit control word set the edges, counted in clock cycles from that reference cycle. Writes have a start offset and a stop offset. Reads have an early release offset and a late re-drive offset. The block also raises a completion strobe at the last edge of the access.

When an offset used by the access is above 10, the access cannot finish inside the 16-clock budget. The block then raises a retry indication in the reference cycle and leaves the data pins released. The same control word also holds three more bits: a local-bus clock gate, a software reset for the local bus, and a strobe-style select. Parallel-port mode forces the strobe-style select to 0.

Top module: `lbus_drive_timer`

## Requirements
- R1: Control word fields are: write-assert [3:0], write-release [7:4], read-assert [11:8], read-release [15:12], software reset bit 29, clock enable bit 30, strobe style bit 31. After reset these hold 0, 15, 4, 0, 0, 0, 0. As a result, a read with the reset values drives from cycle 4, and a write with the reset values is retried.
- R2: During a write, `data_oe` is 1 in transfer cycle k (the reference cycle is k=0) exactly when k >= write-assert and k < write-release.
- R3: During a read, `data_oe` is 1 in cycle k exactly when k < read-release, or when k >= read-assert and k > read-release.
- R4: When an assert offset equals its release offset, the release wins in the cycle where they meet. An equal pair never drives during a write, and the pins are released in that cycle during a read.
- R5: An offset of 0 takes effect in the reference cycle itself, with no added latency.
- R6: `xfer_done` pulses for exactly one cycle, at k equal to the larger of the two active offsets. From the next cycle on, `data_oe` is 0 until the next reference pulse.
- R7: If either offset of the accessed direction exceeds 10, `retry` is 1 in the reference cycle, and neither `data_oe` nor `xfer_done` rises for that access. Offsets of the other direction are ignored.
- R8: `lb_clk` is held at 0 while the clock enable bit is 0. While the bit is 1, `lb_clk` follows `clk`.
- R9: `lb_rst_n` is 0 while the system reset is active or while the software reset bit is 1. Otherwise it is 1.
- R10: `strb_style` equals bit 31 of the control word, except that it is forced to 0 while `par_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word value |
| par_mode | input | 1 | Parallel-port mode; forces strobe style to 0 |
| ref_pulse | input | 1 | Reference cycle of an access (k=0) |
| is_read | input | 1 | Direction of the access, 1 = read |
| lb_clk | output | 1 | Gated local-bus clock |
| lb_rst_n | output | 1 | Active-low local-bus reset |
| strb_style | output | 1 | 0 = separate read/write strobes, 1 = strobe plus direction line |
| data_oe | output | 1 | Data pin drive enable (0 = high impedance) |
| xfer_done | output | 1 | One-cycle completion strobe |
| retry | output | 1 | Access refused because an active offset is out of range |

## Verification
A counter that is off by one moves a `data_oe` edge or the `xfer_done` pulse by one cycle. The cycle-exact sweep over every legal offset pair catches this at the first transfer that uses the affected pair. A wrong latched direction or offset pair shows up within a single transfer as drive in the wrong window. A missing range check lets `data_oe` rise in a transfer that the bench expects to be retried, and it shows in the reference cycle. Errors in the control word decode show as soon as the word is written: a wrong reset value or bit position shows on `lb_clk`, `lb_rst_n` or `strb_style`, or as a retry where none is expected.

// File: rtl/lbdt_pkg.sv
// Package: shared types and helpers for the local bus data-drive timer.
// Assumes every offset is an unsigned cycle count of OFS_W bits.
package lbdt_pkg;
    localparam int OFS_W = 4;

    typedef logic [OFS_W-1:0] ofs_t;

    // One pair of edges for a single transfer direction.
    typedef struct packed {
        ofs_t asrt;
        ofs_t rel;
    } edge_pair_t;

    // Last cycle index at which the pair changes anything.
    function automatic ofs_t pair_end(input edge_pair_t p);
        return (p.asrt > p.rel) ? p.asrt : p.rel;
    endfunction
endpackage

// File: rtl/lbdt_ctl_reg.sv
// Module: control word storage for the data-drive timer.
// Holds the four edge offsets and three control bits. Each cfg_we writes
// the whole word. Reset gives write 0/15, read 4/0 and all control bits 0.
// Assumes cfg_we is synchronous to clk.
module lbdt_ctl_reg
    import lbdt_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int SWRST_BIT = 29,
    parameter int CLKEN_BIT = 30,
    parameter int STYLE_BIT = 31,
    parameter int RD_ASRT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              par_mode,
    output edge_pair_t        wr_pair,
    output edge_pair_t        rd_pair,
    output logic              clk_en,
    output logic              sw_rst,
    output logic              strb_style
);
    localparam ofs_t WR_REL_RST  = '1;
    localparam ofs_t RD_ASRT_VAL = ofs_t'(RD_ASRT_RST);

    logic style_q;
    logic unused_bits;

    // Bits between the offset fields and the control bits carry nothing.
    assign unused_bits = ^cfg_wdata[SWRST_BIT-1:4*OFS_W];

    // Capture the control word on a write, or load the reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pair <= '{asrt: '0, rel: WR_REL_RST};
            rd_pair <= '{asrt: RD_ASRT_VAL, rel: '0};
            clk_en  <= 1'b0;
            sw_rst  <= 1'b0;
            style_q <= 1'b0;
        end else if (cfg_we) begin
            wr_pair.asrt <= cfg_wdata[0*OFS_W +: OFS_W];
            wr_pair.rel  <= cfg_wdata[1*OFS_W +: OFS_W];
            rd_pair.asrt <= cfg_wdata[2*OFS_W +: OFS_W];
            rd_pair.rel  <= cfg_wdata[3*OFS_W +: OFS_W];
            sw_rst       <= cfg_wdata[SWRST_BIT];
            clk_en       <= cfg_wdata[CLKEN_BIT];
            style_q      <= cfg_wdata[STYLE_BIT];
        end
    end

    // Parallel-port mode pins the strobe style to separate strobes.
    assign strb_style = style_q & ~par_mode;

    assert_parallel_style_R10: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode |-> !strb_style);
endmodule

// File: rtl/lbdt_seq.sv
// Module: per-transfer cycle counter and drive-window decode.
// The reference cycle is index 0. The counter runs up to the last edge of
// the active pair and then goes idle. The offset pair and direction are
// taken at the reference pulse and held for the rest of the transfer. A new
// reference pulse restarts the counter even while a transfer is running.
// Assumes ref_pulse is one cycle wide.
module lbdt_seq
    import lbdt_pkg::*;
#(
    parameter int LEGAL_MAX = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_pulse,
    input  logic       is_read,
    input  edge_pair_t wr_pair,
    input  edge_pair_t rd_pair,
    output logic       data_oe,
    output logic       xfer_done,
    output logic       retry
);
    localparam ofs_t LIMIT = ofs_t'(LEGAL_MAX);
    localparam ofs_t ONE   = ofs_t'(1);

    logic       busy_q, dir_q;
    ofs_t       cnt_q;
    edge_pair_t pair_q;

    edge_pair_t live_pair, cur_pair;
    logic       live_bad, start, active, cur_dir, win;
    ofs_t       cur_idx, cur_end;

    // Select the pair for the requested direction and range-check it.
    always_comb begin
        live_pair = is_read ? rd_pair : wr_pair;
        live_bad  = (live_pair.asrt > LIMIT) || (live_pair.rel > LIMIT);
        start     = ref_pulse && !live_bad;
        retry     = ref_pulse && live_bad;
    end

    // Current cycle view: the live inputs at the reference cycle, the held copy after it.
    always_comb begin
        cur_pair = ref_pulse ? live_pair : pair_q;
        cur_dir  = ref_pulse ? is_read   : dir_q;
        cur_idx  = ref_pulse ? '0        : cnt_q;
        cur_end  = pair_end(cur_pair);
        active   = start || (busy_q && !ref_pulse);
    end

    // Drive window; release wins where the assert and release edges meet.
    always_comb begin
        if (cur_dir)
            win = (cur_idx < cur_pair.rel) ||
                  ((cur_idx >= cur_pair.asrt) && (cur_idx > cur_pair.rel));
        else
            win = (cur_idx >= cur_pair.asrt) && (cur_idx < cur_pair.rel);
        data_oe   = active && win;
        xfer_done = active && (cur_idx == cur_end);
    end

    // Advance the cycle index and go idle at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dir_q  <= 1'b0;
            cnt_q  <= '0;
            pair_q <= '0;
        end else if (ref_pulse) begin
            busy_q <= start && (pair_end(live_pair) != '0);
            dir_q  <= is_read;
            cnt_q  <= ONE;
            pair_q <= live_pair;
        end else if (busy_q) begin
            if (cnt_q == pair_end(pair_q))
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q + ONE;
        end
    end

    assert_retry_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (!data_oe && !xfer_done));

    assert_done_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (ref_pulse || (!data_oe && !xfer_done)));

    assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= pair_end(pair_q)));

    assert_zero_write_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && !is_read && !retry && wr_pair.asrt == '0 && wr_pair.rel != '0)
        |-> data_oe);
endmodule

// File: rtl/lbus_drive_timer.sv
// Module: top of the local bus data-drive timer.
// Connects the control word to the transfer sequencer. Also produces the
// gated local-bus clock and the combined local-bus reset.
// Assumes the system reset is synchronous and active low.
module lbus_drive_timer
    import lbdt_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int LEGAL_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              par_mode,
    input  logic              ref_pulse,
    input  logic              is_read,
    output logic              lb_clk,
    output logic              lb_rst_n,
    output logic              strb_style,
    output logic              data_oe,
    output logic              xfer_done,
    output logic              retry
);
    edge_pair_t wr_pair, rd_pair;
    logic       clk_en, sw_rst;

    lbdt_ctl_reg #(.WORD_W(WORD_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .par_mode(par_mode), .wr_pair(wr_pair), .rd_pair(rd_pair),
        .clk_en(clk_en), .sw_rst(sw_rst), .strb_style(strb_style)
    );

    lbdt_seq #(.LEGAL_MAX(LEGAL_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .is_read(is_read),
        .wr_pair(wr_pair), .rd_pair(rd_pair), .data_oe(data_oe),
        .xfer_done(xfer_done), .retry(retry)
    );

    // Local-bus clock: the system clock gated by the enable bit.
    assign lb_clk = clk & clk_en;

    // Local-bus reset: the system reset or the software reset bit.
    assign lb_rst_n = rst_n & ~sw_rst;

    assert_swrst_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |-> !lb_rst_n);
endmodule

// File: tb/lbus_drive_timer_test.sv
// Bench: sweeps every legal offset pair in both directions, every illegal
// value in each active field, and the control bits.
module lbus_drive_timer_test;
    logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, par_mode = 1'b0;
    logic ref_pulse = 1'b0, is_read = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic lb_clk, lb_rst_n, strb_style, data_oe, xfer_done, retry;
    int total = 0, bad = 0;

    lbus_drive_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .par_mode(par_mode), .ref_pulse(ref_pulse), .is_read(is_read),
        .lb_clk(lb_clk), .lb_rst_n(lb_rst_n), .strb_style(strb_style),
        .data_oe(data_oe), .xfer_done(xfer_done), .retry(retry)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word(input bit rd, input int a, input int r);
        return rd ? 32'((r << 12) | (a << 8)) : 32'((r << 4) | a);
    endfunction

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Starts at a negedge; drives one legal transfer and checks every cycle.
    task automatic xfer(input bit rd, input int a, input int r, input string req);
        int e = (a > r) ? a : r;
        ref_pulse = 1'b1;
        is_read = rd;
        for (int k = 0; k <= e + 1; k++) begin
            bit exp_oe;
            if (k > 0) begin
                @(negedge clk);
                ref_pulse = 1'b0;
            end
            #5;
            if (k > e) exp_oe = 1'b0;
            else if (rd) exp_oe = (k < r) || (k >= a && k > r);
            else exp_oe = (k >= a) && (k < r);
            check(req, data_oe, exp_oe);
            check("R6 done", xfer_done, k == e);
            if (k == 0) check("R7 no retry", retry, 1'b0);
        end
    endtask

    // One out-of-range value in the accessed direction.
    task automatic bad_xfer(input bit rd, input int v, input bit on_rel);
        cfg_write(on_rel ? word(rd, 0, v) : word(rd, v, 0));
        ref_pulse = 1'b1;
        is_read = rd;
        #5;
        check("R7 retry", retry, 1'b1);
        check("R7 oe", data_oe, 1'b0);
        check("R7 done", xfer_done, 1'b0);
        @(negedge clk);
        ref_pulse = 1'b0;
        #5;
        check("R7 oe after", data_oe, 1'b0);
        check("R7 done after", xfer_done, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R9 sys reset", lb_rst_n, 1'b0);
        check("R1 reset oe", data_oe, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R9 released", lb_rst_n, 1'b1);
        check("R1 reset retry", retry, 1'b0);
        check("R1 reset style", strb_style, 1'b0);
        check("R8 reset clock", lb_clk, 1'b0);

        // R1: reset offsets give read 4/0 legal and write 0/15 retried.
        @(negedge clk);
        xfer(1'b1, 4, 0, "R1 default read");
        @(negedge clk);
        ref_pulse = 1'b1;
        is_read = 1'b0;
        #5;
        check("R1 default write retry", retry, 1'b1);
        @(negedge clk);
        ref_pulse = 1'b0;

        // R2 R3 R4 R5: every legal pair in both directions.
        for (int d = 0; d < 2; d++)
            for (int a = 0; a <= 10; a++)
                for (int r = 0; r <= 10; r++) begin
                    string tag;
                    if (a == r) tag = "R4 equal";
                    else if (a == 0 || r == 0) tag = "R5 zero";
                    else tag = (d == 1) ? "R3 read" : "R2 write";
                    cfg_write(word(d == 1, a, r));
                    xfer(d == 1, a, r, tag);
                end

        // R7: every illegal value in each active field.
        for (int d = 0; d < 2; d++)
            for (int v = 11; v <= 15; v++) begin
                bad_xfer(d == 1, v, 1'b0);
                bad_xfer(d == 1, v, 1'b1);
            end

        // R7: bad write fields do not affect a read.
        cfg_write(word(1'b1, 3, 1) | 32'h0000_00FF);
        xfer(1'b1, 3, 1, "R7 other dir ignored");

        // R8: clock gate.
        cfg_write(32'h4000_0000);
        @(posedge clk);
        #5;
        check("R8 clk high", lb_clk, 1'b1);
        @(negedge clk);
        #5;
        check("R8 clk low", lb_clk, 1'b0);
        cfg_write(32'h0);
        @(posedge clk);
        #5;
        check("R8 gated", lb_clk, 1'b0);

        // R9: software reset bit.
        cfg_write(32'h2000_0000);
        #5;
        check("R9 sw reset", lb_rst_n, 1'b0);
        cfg_write(32'h0);
        #5;
        check("R9 sw release", lb_rst_n, 1'b1);

        // R10: strobe style and the parallel-port override.
        cfg_write(32'h8000_0000);
        #5;
        check("R10 style", strb_style, 1'b1);
        par_mode = 1'b1;
        #1;
        check("R10 par forced", strb_style, 1'b0);
        par_mode = 1'b0;
        #1;
        check("R10 style back", strb_style, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule